// File: doc/BRIEF.md
# Dual-Thread Interleaved Instruction Fetch Unit

This block fetches 16-bit instructions for two hardware threads from one shared instruction memory port. The address port is time-multiplexed on the two clock phases. While the clock is high it carries thread 0's program counter, and while it is low it carries thread 1's. The memory returns the addressed halfword within the same half cycle. Each thread therefore receives exactly one fetch slot per core cycle. The two instructions delivered together in a cycle always belong to different threads, so they never depend on each other.

Each thread keeps its own 32-bit program counter, which steps by 2 bytes per instruction. Unconditional PC-relative jumps are followed at fetch time. Conditional branch-if-zero-and-link instructions are predicted with a table of 2-bit saturating counters that both threads share. A resolution port from the execution side trains the counters. When a prediction was wrong, the same port moves only the affected thread to the correct target. If the fetch unit predicts that a branch-and-link is taken, it raises a side-band request so that the back end can write the link register. The fetch unit does not write that register itself.

Top module: `dual_thread_fetch`

## Requirements
- R1: While rst_n is low, both fetchValid bits are 0. On the first cycle after release, thread 0 presents the instruction at 0x0000 and thread 1 presents the instruction at 0x0800. Every predictor counter starts at 1, meaning weakly not-taken.
- R2: In each unstalled cycle, each thread presents one valid instruction together with its address. The next address of a non-branching instruction is that address plus 2. imemAddr carries thread 0's PC while clk is high and thread 1's PC while clk is low.
- R3: A jump has opcode bits [15:12] = 0xC and a signed 12-bit byte offset in bits [11:0]. It is reported with fetchPredTaken = 1, and that thread's next fetch address is the jump's own address plus the sign-extended offset.
- R4: A branch-and-link has opcode bits [15:12] = 0xD, a register field in bits [11:8] and a signed 8-bit byte offset in bits [7:0]. When its counter is below 2, it is reported with fetchPredTaken = 0 and linkReq = 0, and the next address is its own address plus 2.
- R5: When the counter of a branch-and-link is 2 or 3, it is reported with fetchPredTaken = 1 and linkReq = 1. The next address is its own address plus the sign-extended 8-bit offset.
- R6: Each resolution adjusts the counter selected by resPc, whether or not a misprediction is flagged. A taken outcome raises the counter, saturating at 3. A not-taken outcome lowers it, saturating at 0.
- R7: A resolution flagged as mispredicted redirects only thread resTid. On the next cycle that thread's fetchValid is 0. On the cycle after, it presents the instruction at resTarget. The other thread keeps advancing every cycle without a gap.
- R8: While stall[t] is 1, thread t's fetchValid, fetchPc, fetchInstr, fetchPredTaken and linkReq hold their values. The thread resumes at the following address once the stall is released. The other thread is unaffected.
- R9: A misprediction redirect takes effect even when the thread is stalled. The thread then shows fetchValid = 0 until the stall is released, and its next instruction comes from resTarget.
- R10: The counter table is indexed by address bits [6:1]. Branches whose addresses differ by a multiple of 128 bytes share one counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; both edges are used for the memory port |
| rst_n | input | 1 | Active-low asynchronous reset |
| imemAddr | output | 32 | Shared memory byte address: thread 0 PC while clk high, thread 1 PC while clk low |
| imemData | input | 16 | Halfword returned for imemAddr within the half cycle |
| stall | input | 2 | Per-thread hold request, bit t for thread t |
| resValid | input | 1 | A branch resolution is present this cycle |
| resTid | input | 1 | Thread the resolution belongs to |
| resPc | input | 32 | Address of the resolved branch, selects the counter |
| resTaken | input | 1 | Actual branch outcome |
| resTarget | input | 32 | Correct next address of the resolving thread |
| resMispredict | input | 1 | The prediction was wrong; redirect thread resTid |
| fetchValid | output | 2 | Per-thread output holds a real instruction |
| fetchInstr | output | 2x16 | Per-thread fetched instruction |
| fetchPc | output | 2x32 | Per-thread address of the fetched instruction |
| fetchPredTaken | output | 2 | Per-thread: fetch followed a jump or a predicted-taken branch |
| linkReq | output | 2 | Per-thread request to write the link register with fetchPc |

## Verification
A counter table left in the wrong state does not show at once. It appears only when a branch-and-link is next fetched from an address that maps to the damaged entry, so the tests rebuild each counter value through the resolution port and then steer the thread back to the branch to read the prediction. A wrong program counter shows within one cycle as a wrong fetchPc and fetchInstr on that thread. A wrong phase selection on the shared memory port swaps or duplicates the instructions of the two threads, which shows on the first cycle after reset. Stall and redirect errors show either as a missing bubble in the cycle right after the event or as a gap on the thread that should have been left alone.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int INSTR_W = 16;
  localparam int NUM_THR = 2;
  localparam logic [3:0] OP_JUMP = 4'hC;
  localparam logic [3:0] OP_BZL  = 4'hD;

  typedef struct packed {
    logic redirect;
    logic advance;
  } thrStrobe_t;

  typedef struct packed {
    thrStrobe_t [NUM_THR-1:0] thr;
    logic                     cntInc;
    logic                     cntDec;
  } ctlStrobe_t;
endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
(
  input  logic [NUM_THR-1:0] stall,
  input  logic               resValid,
  input  logic               resTid,
  input  logic               resTaken,
  input  logic               resMispredict,
  output ctlStrobe_t         ctl
);
  logic [NUM_THR-1:0] redirectHit;

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    assign redirectHit[t]     = resValid && resMispredict && (resTid == t[0]);
    assign ctl.thr[t].redirect = redirectHit[t];
    assign ctl.thr[t].advance  = !stall[t] && !redirectHit[t];
  end

  assign ctl.cntInc = resValid && resTaken;
  assign ctl.cntDec = resValid && !resTaken;
endmodule

// File: rtl/fetch_pred.sv
module fetch_pred
  import fetch_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 64
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_THR-1:0][ADDR_W-1:0] rdPc,
  output logic [NUM_THR-1:0]             rdTaken,
  input  logic [ADDR_W-1:0]              wrPc,
  input  logic                           cntInc,
  input  logic                           cntDec
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [1:0] cntTable [ENTRIES];
  logic [IDX_W-1:0] wrIdx;

  assign wrIdx = wrPc[IDX_W:1];

  for (genvar t = 0; t < NUM_THR; t++) begin : g_rd
    logic [IDX_W-1:0] rdIdx;
    assign rdIdx      = rdPc[t][IDX_W:1];
    assign rdTaken[t] = cntTable[rdIdx][1];
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cntTable[e] <= 2'd1;
      end else if (wrIdx == e[IDX_W-1:0]) begin
        if (cntInc && cntTable[e] != 2'd3) cntTable[e] <= cntTable[e] + 2'd1;
        else if (cntDec && cntTable[e] != 2'd0) cntTable[e] <= cntTable[e] - 2'd1;
      end
    end
  end
endmodule

// File: rtl/fetch_dp.sv
module fetch_dp
  import fetch_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_PC0 = '0,
  parameter logic [ADDR_W-1:0] RESET_PC1 = 'h800
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  ctlStrobe_t                      ctl,
  output logic [ADDR_W-1:0]               imemAddr,
  input  logic [INSTR_W-1:0]              imemData,
  input  logic [ADDR_W-1:0]               resTarget,
  input  logic [NUM_THR-1:0]              predTaken,
  output logic [NUM_THR-1:0][ADDR_W-1:0]  pcCur,
  output logic [NUM_THR-1:0]              fetchValid,
  output logic [NUM_THR-1:0][INSTR_W-1:0] fetchInstr,
  output logic [NUM_THR-1:0][ADDR_W-1:0]  fetchPc,
  output logic [NUM_THR-1:0]              fetchPredTaken,
  output logic [NUM_THR-1:0]              linkReq
);
  logic [INSTR_W-1:0] highPhaseWord;

  // Thread 0 owns the high phase, thread 1 the low phase.
  assign imemAddr = clk ? pcCur[0] : pcCur[1];

  // Word fetched for thread 0 is parked at the falling edge.
  always_ff @(negedge clk) begin
    highPhaseWord <= imemData;
  end

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    localparam logic [ADDR_W-1:0] START_PC = (t == 0) ? RESET_PC0 : RESET_PC1;

    logic [INSTR_W-1:0] curWord;
    logic               isJump;
    logic               isBzl;
    logic [ADDR_W-1:0]  jumpOfs;
    logic [ADDR_W-1:0]  bzlOfs;
    logic               followTarget;
    logic [ADDR_W-1:0]  targetPc;
    logic [ADDR_W-1:0]  nextPc;

    assign curWord      = (t == 0) ? highPhaseWord : imemData;
    assign isJump       = curWord[15:12] == OP_JUMP;
    assign isBzl        = curWord[15:12] == OP_BZL;
    assign jumpOfs      = {{(ADDR_W-12){curWord[11]}}, curWord[11:0]};
    assign bzlOfs       = {{(ADDR_W-8){curWord[7]}}, curWord[7:0]};
    assign followTarget = isJump || (isBzl && predTaken[t]);
    assign targetPc     = pcCur[t] + (isJump ? jumpOfs : bzlOfs);
    assign nextPc       = followTarget ? targetPc : pcCur[t] + ADDR_W'(2);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pcCur[t]          <= START_PC;
        fetchValid[t]     <= 1'b0;
        fetchInstr[t]     <= '0;
        fetchPc[t]        <= '0;
        fetchPredTaken[t] <= 1'b0;
        linkReq[t]        <= 1'b0;
      end else if (ctl.thr[t].redirect) begin
        pcCur[t]          <= resTarget;
        fetchValid[t]     <= 1'b0;
        fetchPredTaken[t] <= 1'b0;
        linkReq[t]        <= 1'b0;
      end else if (ctl.thr[t].advance) begin
        pcCur[t]          <= nextPc;
        fetchValid[t]     <= 1'b1;
        fetchInstr[t]     <= curWord;
        fetchPc[t]        <= pcCur[t];
        fetchPredTaken[t] <= followTarget;
        linkReq[t]        <= isBzl && predTaken[t];
      end
    end
  end
endmodule

// File: rtl/dual_thread_fetch.sv
module dual_thread_fetch
  import fetch_pkg::*;
#(
  parameter int                ADDR_W       = 32,
  parameter int                PRED_ENTRIES = 64,
  parameter logic [ADDR_W-1:0] RESET_PC0    = '0,
  parameter logic [ADDR_W-1:0] RESET_PC1    = 'h800
) (
  input  logic                            clk,
  input  logic                            rst_n,
  output logic [ADDR_W-1:0]               imemAddr,
  input  logic [INSTR_W-1:0]              imemData,
  input  logic [NUM_THR-1:0]              stall,
  input  logic                            resValid,
  input  logic                            resTid,
  input  logic [ADDR_W-1:0]               resPc,
  input  logic                            resTaken,
  input  logic [ADDR_W-1:0]               resTarget,
  input  logic                            resMispredict,
  output logic [NUM_THR-1:0]              fetchValid,
  output logic [NUM_THR-1:0][INSTR_W-1:0] fetchInstr,
  output logic [NUM_THR-1:0][ADDR_W-1:0]  fetchPc,
  output logic [NUM_THR-1:0]              fetchPredTaken,
  output logic [NUM_THR-1:0]              linkReq
);
  ctlStrobe_t                     ctl;
  logic [NUM_THR-1:0][ADDR_W-1:0] pcCur;
  logic [NUM_THR-1:0]             predTaken;

  fetch_ctrl u_ctrl (
    .stall(stall), .resValid(resValid), .resTid(resTid),
    .resTaken(resTaken), .resMispredict(resMispredict), .ctl(ctl)
  );

  fetch_pred #(.ADDR_W(ADDR_W), .ENTRIES(PRED_ENTRIES)) u_pred (
    .clk(clk), .rst_n(rst_n), .rdPc(pcCur), .rdTaken(predTaken),
    .wrPc(resPc), .cntInc(ctl.cntInc), .cntDec(ctl.cntDec)
  );

  fetch_dp #(.ADDR_W(ADDR_W), .RESET_PC0(RESET_PC0), .RESET_PC1(RESET_PC1)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .imemAddr(imemAddr),
    .imemData(imemData), .resTarget(resTarget), .predTaken(predTaken),
    .pcCur(pcCur), .fetchValid(fetchValid), .fetchInstr(fetchInstr),
    .fetchPc(fetchPc), .fetchPredTaken(fetchPredTaken), .linkReq(linkReq)
  );
endmodule

// File: rtl/fetch_chk.sv
module fetch_chk
  import fetch_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [NUM_THR-1:0]              stall,
  input logic                            resValid,
  input logic                            resTid,
  input logic                            resMispredict,
  input logic [NUM_THR-1:0]              fetchValid,
  input logic [NUM_THR-1:0][INSTR_W-1:0] fetchInstr,
  input logic [NUM_THR-1:0][ADDR_W-1:0]  fetchPc,
  input logic [NUM_THR-1:0]              fetchPredTaken,
  input logic [NUM_THR-1:0]              linkReq
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> fetchValid == '0);

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    // R7
    bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resValid && resMispredict && (resTid == t[0]) |=> !fetchValid[t]);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall[t] && !(resValid && resMispredict && (resTid == t[0]))
      |=> $stable(fetchPc[t]) && $stable(fetchInstr[t]) && $stable(fetchValid[t]));

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetchValid[t] && $past(fetchValid[t]) && !$past(fetchPredTaken[t]) && !$past(stall[t])
      |-> fetchPc[t] == $past(fetchPc[t]) + ADDR_W'(2));

    // R3
    jump_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetchValid[t] && fetchInstr[t][15:12] == OP_JUMP |-> fetchPredTaken[t]);

    // R5
    link_only_bzl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      linkReq[t] |-> fetchValid[t] && fetchPredTaken[t] && fetchInstr[t][15:12] == OP_BZL);
  end
endmodule

bind dual_thread_fetch fetch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .resValid(resValid),
  .resTid(resTid), .resMispredict(resMispredict), .fetchValid(fetchValid),
  .fetchInstr(fetchInstr), .fetchPc(fetchPc), .fetchPredTaken(fetchPredTaken),
  .linkReq(linkReq)
);

// File: tb/dual_thread_fetch_tb.sv
`timescale 1ns/1ps
module dual_thread_fetch_tb;
  localparam int AW = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [AW-1:0]     imemAddr;
  logic [15:0]       imemData = '0;
  logic [1:0]        stall = '0;
  logic              resValid = 1'b0;
  logic              resTid = 1'b0;
  logic [AW-1:0]     resPc = '0;
  logic              resTaken = 1'b0;
  logic [AW-1:0]     resTarget = '0;
  logic              resMispredict = 1'b0;
  logic [1:0]        fetchValid;
  logic [1:0][15:0]  fetchInstr;
  logic [1:0][AW-1:0] fetchPc;
  logic [1:0]        fetchPredTaken;
  logic [1:0]        linkReq;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  logic [15:0] mem [0:2047];

  always #2 clk = ~clk;

  always @(imemAddr) imemData <= #1 mem[imemAddr[11:1]];

  dual_thread_fetch u_dut (
    .clk(clk), .rst_n(rst_n), .imemAddr(imemAddr), .imemData(imemData),
    .stall(stall), .resValid(resValid), .resTid(resTid), .resPc(resPc),
    .resTaken(resTaken), .resTarget(resTarget), .resMispredict(resMispredict),
    .fetchValid(fetchValid), .fetchInstr(fetchInstr), .fetchPc(fetchPc),
    .fetchPredTaken(fetchPredTaken), .linkReq(linkReq)
  );

  function automatic logic [15:0] plainWord(input logic [AW-1:0] a);
    return {4'h1, a[12:1]};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chkOut(input string req, input int t, input logic [AW-1:0] pc,
                        input logic [15:0] instr, input logic pred, input logic link);
    chk(req, $sformatf("t%0d valid", t), 32'(fetchValid[t]), 32'd1);
    chk(req, $sformatf("t%0d pc", t), fetchPc[t], pc);
    chk(req, $sformatf("t%0d instr", t), 32'(fetchInstr[t]), 32'(instr));
    chk(req, $sformatf("t%0d predTaken", t), 32'(fetchPredTaken[t]), 32'(pred));
    chk(req, $sformatf("t%0d linkReq", t), 32'(linkReq[t]), 32'(link));
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clearRes();
    resValid = 0; resMispredict = 0; resTaken = 0; resTid = 0; resPc = '0; resTarget = '0;
  endtask

  // Holds reset, loads plain words; caller patches memory then calls release.
  task automatic holdReset();
    rst_n = 0; stall = '0; clearRes();
    for (int i = 0; i < 2048; i++) mem[i] = plainWord(AW'(i * 2));
    step(); step();
  endtask

  task automatic releaseReset();
    rst_n = 1;
  endtask

  task automatic sendRes(input logic tid, input logic [AW-1:0] pc, input logic taken,
                         input logic [AW-1:0] tgt, input logic mis);
    resValid = 1; resTid = tid; resPc = pc; resTaken = taken; resTarget = tgt; resMispredict = mis;
  endtask

  task automatic testReset();
    holdReset();
    chk("R1", "valid during reset", 32'(fetchValid), 32'd0);
    releaseReset(); step();
    chkOut("R1", 0, 32'h0, plainWord(32'h0), 0, 0);
    chkOut("R1", 1, 32'h800, plainWord(32'h800), 0, 0);
  endtask

  task automatic testSequential();
    holdReset(); releaseReset();
    for (int k = 0; k < 8; k++) begin
      step();
      chkOut("R2", 0, AW'(2 * k), plainWord(AW'(2 * k)), 0, 0);
      chkOut("R2", 1, AW'(32'h800 + 2 * k), plainWord(AW'(32'h800 + 2 * k)), 0, 0);
    end
  endtask

  task automatic testJump();
    holdReset();
    mem[3] = 16'hC020;                 // jump +0x20 at 0x6
    mem[(32'h804 >> 1)] = 16'hCFFC;    // jump -4 at 0x804
    releaseReset();
    step(); step(); step();
    chkOut("R3", 1, 32'h804, 16'hCFFC, 1, 0);
    step();
    chkOut("R3", 0, 32'h6, 16'hC020, 1, 0);
    chkOut("R3", 1, 32'h800, plainWord(32'h800), 0, 0);
    step();
    chkOut("R3", 0, 32'h26, plainWord(32'h26), 0, 0);
    step();
    chkOut("R3", 0, 32'h28, plainWord(32'h28), 0, 0);
    chkOut("R3", 1, 32'h804, 16'hCFFC, 1, 0);
  endtask

  task automatic testBzlNotTaken();
    holdReset();
    mem[2] = 16'hD108;                 // bzl r1, +8 at 0x4
    releaseReset();
    step(); step(); step();
    chkOut("R4", 0, 32'h4, 16'hD108, 0, 0);
    step();
    chkOut("R4", 0, 32'h6, plainWord(32'h6), 0, 0);
  endtask

  // Redirect thread 0 to 0 and watch it reach the branch at 0x4 again.
  task automatic redirectAndRefetch(input string req, input logic taken, input logic expPred);
    logic [AW-1:0] pc1;
    sendRes(0, 32'h4, taken, 32'h0, 1);
    step(); clearRes();
    chk(req, "bubble after redirect", 32'(fetchValid[0]), 32'd0);
    pc1 = fetchPc[1];
    step();
    chkOut(req, 0, 32'h0, plainWord(32'h0), 0, 0);
    chk("R7", "other thread continues", fetchPc[1], pc1 + 2);
    step();
    step();
    chkOut(req, 0, 32'h4, 16'hD108, expPred, expPred);
    step();
    chk(req, "after branch", fetchPc[0], expPred ? 32'hC : 32'h6);
  endtask

  task automatic testTrainAndRedirect();
    holdReset();
    mem[2] = 16'hD108;
    releaseReset();
    step(); step(); step();
    chkOut("R4", 0, 32'h4, 16'hD108, 0, 0);
    chk("R7", "t1 before redirect", fetchPc[1], 32'h804);
    sendRes(0, 32'h4, 1, 32'h0, 1);
    step(); clearRes();
    chk("R7", "t0 bubble", 32'(fetchValid[0]), 32'd0);
    chkOut("R7", 1, 32'h806, plainWord(32'h806), 0, 0);
    step();
    chkOut("R7", 0, 32'h0, plainWord(32'h0), 0, 0);
    chkOut("R7", 1, 32'h808, plainWord(32'h808), 0, 0);
    step(); step();
    chkOut("R5", 0, 32'h4, 16'hD108, 1, 1);
    step();
    chkOut("R5", 0, 32'hC, plainWord(32'hC), 0, 0);
  endtask

  task automatic testSaturation();
    holdReset();
    mem[2] = 16'hD108;
    releaseReset();
    sendRes(0, 32'h4, 1, 32'h0, 0);
    for (int i = 0; i < 4; i++) step();   // 1 -> 3, saturated
    clearRes();
    redirectAndRefetch("R6", 0, 1);       // 3 -> 2: still taken
    sendRes(0, 32'h4, 0, 32'h0, 0);
    for (int i = 0; i < 4; i++) step();   // 2 -> 0, saturated
    clearRes();
    redirectAndRefetch("R6", 1, 0);       // 0 -> 1: not taken
  endtask

  task automatic testStall();
    logic [AW-1:0] held;
    holdReset(); releaseReset();
    step(); step();
    held = fetchPc[1];
    stall = 2'b10;
    for (int i = 0; i < 3; i++) begin
      step();
      chkOut("R8", 1, held, plainWord(held), 0, 0);
      chk("R8", "t0 not stalled", fetchPc[0], AW'(2 * (i + 2)));
    end
    stall = 2'b00;
    step();
    chkOut("R8", 1, held + 2, plainWord(held + 2), 0, 0);
  endtask

  task automatic testRedirectWhileStalled();
    holdReset(); releaseReset();
    step(); step();
    stall = 2'b01;
    sendRes(0, 32'h40, 1, 32'h100, 1);
    step(); clearRes();
    chk("R9", "bubble under stall", 32'(fetchValid[0]), 32'd0);
    step();
    chk("R9", "bubble held", 32'(fetchValid[0]), 32'd0);
    stall = 2'b00;
    step();
    chkOut("R9", 0, 32'h100, plainWord(32'h100), 0, 0);
    chk("R9", "t1 running", fetchPc[1], 32'h808);
  endtask

  task automatic testAlias();
    holdReset();
    mem[2] = 16'hD108;
    sendRes(1, 32'h84, 1, 32'h0, 0);    // trains entry shared with 0x4
    releaseReset();
    step(); step(); clearRes();
    step();
    chkOut("R10", 0, 32'h4, 16'hD108, 1, 1);
  endtask

  initial begin
    testReset();
    testSequential();
    testJump();
    testBzlNotTaken();
    testTrainAndRedirect();
    testSaturation();
    testStall();
    testRedirectWhileStalled();
    testAlias();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule